// File: doc/BRIEF.md
# Combo PHY Power-Up Sequencer

This block brings a multi-protocol serial PHY (PCIe, SATA or USB3) out of power-down and puts it back, with no software stepping through the sequence. An init request checks the requested protocol. If the protocol is accepted, the block works through a fixed series of steps:

- it writes the protocol code into a shared control register;
- it enables the PHY's line codec;
- it turns on the reference clock, releases the power-on reset and turns on the clock output to the link partner;
- it waits a settle time;
- it programs three tuning values through the PHY's internal test port.

An exit request undoes the power steps in reverse order.

The PHY is controlled through a 32-bit configuration word. The shared control register is updated by read-modify-write: the block reads the current value on `ctrl_in`, replaces only the mode field and presents the result on `ctrl_out` with a one-cycle write enable. Instance zero of the PHY is hard-wired to USB3. A parameter tells the block whether it drives that instance, and in that case it never writes the mode field.

Top module: `combo_phy_seq`

## Requirements
- R1: After reset the configuration word is 0x8000_0000 (codec bypass set, everything else clear), `refclk_en` is 0, `por_rst` is 1, and `busy`, `done`, `err` and `ctrl_we` are 0.
- R2: Protocol codes are PCIe = 0, USB3 = 1 and SATA = 2. On an accepted init for an instance other than zero, `ctrl_we` pulses exactly once. With that pulse, `ctrl_out` equals the `ctrl_in` value with bits 12:11 replaced by the code and every other bit unchanged.
- R3: An init request with code 3 raises `err` for one cycle with `busy` low. The configuration word, `refclk_en`, `por_rst` and `ctrl_we` do not change.
- R4: On instance zero, an init with any code other than USB3 (1) is rejected as in R3. An accepted init there completes with no `ctrl_we` pulse.
- R5: Power-up proceeds in this order, each step in a later cycle than the one before: clear codec bypass (bit 31), raise `refclk_en`, drop `por_rst`, set the clock-output enable (bit 0).
- R6: No test-port field changes until bit 0 has been set for at least SETTLE_CYCLES clock cycles.
- R7: Each test-port write first holds address (bits 16:12) and data (bits 23:20) steady. The strobe (bit 24) then goes low for at least one cycle and then high. Address and data do not change on the cycle the strobe falls or on the cycle it rises. The PHY latches the write on the rising strobe.
- R8: Exactly three test-port writes are issued, in this order: address 0x01 with data 0x8, address 0x0C with data 0x9, address 0x1A with data 0x4.
- R9: Exit clears bit 0 first, then raises `por_rst`, then drops `refclk_en`, each in a later cycle, and makes no test-port write and no `ctrl_we` pulse.
- R10: `busy` stays high from acceptance until the cycle `done` pulses, and `done` pulses once. Init or exit requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start a power-up sequence (taken only when idle) |
| exit_req | input | 1 | Start a power-down sequence (taken only when idle; init wins a tie) |
| mode_req | input | 2 | Requested protocol code |
| ctrl_in | input | 32 | Current value of the shared control register |
| ctrl_out | output | 32 | Control register value to write back |
| ctrl_we | output | 1 | One-cycle write enable for `ctrl_out` |
| cfg_word | output | 32 | PHY configuration word |
| refclk_en | output | 1 | Reference clock enable |
| por_rst | output | 1 | PHY power-on reset, active high |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence finishes |
| err | output | 1 | One-cycle pulse when an init is rejected |

## Verification
The bench drives randomly chosen protocol codes over random control-register contents, which catches a read-modify-write that disturbs neighbouring bits or writes the wrong position. It feeds codes that must be refused on both instances: a design that let an illegal code through would change outputs or raise `busy` where only `err` is allowed. It also pokes init and exit while a sequence runs, where a design that failed to ignore them would issue extra strobes or extra register writes. Cycle ordering is measured from the outputs, so swapped power steps, a settle wait that is too short, or address and data that move while the strobe toggles each show up as a reported order or distance mismatch.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int CFG_W     = 32;
    localparam int BIT_BYP   = 31;
    localparam int BIT_OEN   = 0;
    localparam int ADR_W     = 5;
    localparam int DAT_W     = 4;
    localparam int MODE_LSB  = 11;
    localparam int NUM_TP_WR = 3;

    localparam logic [1:0] MODE_PCIE = 2'd0;
    localparam logic [1:0] MODE_USB3 = 2'd1;
    localparam logic [1:0] MODE_SATA = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_MODE, ST_BYP, ST_CLK, ST_REL, ST_OEN, ST_SETTLE,
        ST_TPORT, ST_FIN, ST_XOEN, ST_XRST, ST_XCLK
    } seq_state_e;

    typedef struct packed {
        logic [ADR_W-1:0] addr;
        logic [DAT_W-1:0] data;
        logic             strobe;
    } tport_s;

    function automatic logic [ADR_W-1:0] tp_addr(input int idx);
        case (idx)
            0:       return 5'h01;
            1:       return 5'h0C;
            default: return 5'h1A;
        endcase
    endfunction

    function automatic logic [DAT_W-1:0] tp_data(input int idx);
        case (idx)
            0:       return 4'h8;
            1:       return 4'h9;
            default: return 4'h4;
        endcase
    endfunction

    function automatic logic mode_ok(input logic [1:0] m, input logic fixed_usb3);
        if (fixed_usb3) return m == MODE_USB3;
        return m != 2'd3;
    endfunction

    function automatic logic [CFG_W-1:0] rmw_mode(input logic [CFG_W-1:0] cur,
                                                  input logic [1:0] m);
        logic [CFG_W-1:0] v;
        v = cur;
        v[MODE_LSB +: 2] = m;
        return v;
    endfunction

    // bit 31 bypass, 24 strobe, 23:20 data, 16:12 addr, 0 clock-output enable
    function automatic logic [CFG_W-1:0] build_cfg(input logic byp, input tport_s tp,
                                                   input logic oen);
        return {byp, 6'b0, tp.strobe, tp.data, 3'b0, tp.addr, 11'b0, oen};
    endfunction

endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= CW'(CYCLES);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == CW'(1));

    // R6: expiry is a single-cycle event per load
    p_exp_single_r6: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> !expired);

endmodule

// File: rtl/cps_tport.sv
module cps_tport
    import cps_pkg::*;
#(
    parameter int NUM_WR = NUM_TP_WR
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    output tport_s tp,
    output logic   fin
);
    localparam int IW = $clog2(NUM_WR + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_LOW, PH_HIGH} phase_e;

    phase_e        phase;
    logic [IW-1:0] idx;

    assign fin = (phase == PH_HIGH) && (idx == IW'(NUM_WR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            tp    <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go) phase <= PH_LOAD;
                PH_LOAD: begin
                    tp.addr <= tp_addr(int'(idx));
                    tp.data <= tp_data(int'(idx));
                    phase   <= PH_LOW;
                end
                PH_LOW: begin
                    tp.strobe <= 1'b0;
                    phase     <= PH_HIGH;
                end
                PH_HIGH: begin
                    tp.strobe <= 1'b1;
                    if (fin) begin
                        idx   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        phase <= PH_LOAD;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7: strobe low lasts one cycle and is followed by the rising edge
    p_stb_low_then_high_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tp.strobe) |=> $rose(tp.strobe));
    // R7: address and data held while the strobe moves
    p_stb_rise_stable_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tp.strobe) |-> ($stable(tp.addr) && $stable(tp.data)));
    p_stb_fall_stable_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tp.strobe) |-> ($stable(tp.addr) && $stable(tp.data)));

endmodule

// File: rtl/combo_phy_seq.sv
module combo_phy_seq
    import cps_pkg::*;
#(
    parameter int INSTANCE      = 1,
    parameter int SETTLE_CYCLES = 500000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init_req,
    input  logic        exit_req,
    input  logic [1:0]  mode_req,
    input  logic [31:0] ctrl_in,
    output logic [31:0] ctrl_out,
    output logic        ctrl_we,
    output logic [31:0] cfg_word,
    output logic        refclk_en,
    output logic        por_rst,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam logic FIXED_USB3 = (INSTANCE == 0);

    seq_state_e state;
    logic [1:0] mode_q;
    logic       byp_q, oen_q;
    logic       tmr_exp, tp_fin;
    tport_s     tp;

    assign busy     = (state != ST_IDLE);
    assign cfg_word = build_cfg(byp_q, tp, oen_q);

    cps_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .load(state == ST_OEN), .expired(tmr_exp));

    cps_tport #(.NUM_WR(NUM_TP_WR)) u_tport (
        .clk(clk), .rst(rst), .go(state == ST_TPORT), .tp(tp), .fin(tp_fin));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode_q    <= FIXED_USB3 ? MODE_USB3 : MODE_PCIE;
            byp_q     <= 1'b1;
            oen_q     <= 1'b0;
            refclk_en <= 1'b0;
            por_rst   <= 1'b1;
            ctrl_we   <= 1'b0;
            ctrl_out  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            ctrl_we <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (init_req) begin
                        if (mode_ok(mode_req, FIXED_USB3)) begin
                            mode_q <= mode_req;
                            state  <= ST_MODE;
                        end else begin
                            err <= 1'b1;
                        end
                    end else if (exit_req) begin
                        state <= ST_XOEN;
                    end
                end
                ST_MODE: begin
                    if (!FIXED_USB3) begin
                        ctrl_we  <= 1'b1;
                        ctrl_out <= rmw_mode(ctrl_in, mode_q);
                    end
                    state <= ST_BYP;
                end
                ST_BYP:    begin byp_q     <= 1'b0; state <= ST_CLK;    end
                ST_CLK:    begin refclk_en <= 1'b1; state <= ST_REL;    end
                ST_REL:    begin por_rst   <= 1'b0; state <= ST_OEN;    end
                ST_OEN:    begin oen_q     <= 1'b1; state <= ST_SETTLE; end
                ST_SETTLE: if (tmr_exp) state <= ST_TPORT;
                ST_TPORT:  if (tp_fin)  state <= ST_FIN;
                ST_XOEN:   begin oen_q     <= 1'b0; state <= ST_XRST;   end
                ST_XRST:   begin por_rst   <= 1'b1; state <= ST_XCLK;   end
                ST_XCLK:   begin refclk_en <= 1'b0; state <= ST_FIN;    end
                ST_FIN:    begin done      <= 1'b1; state <= ST_IDLE;   end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // R5: reset may be released only while the reference clock runs
    p_rel_needs_clk_r5: assert property (@(posedge clk) disable iff (rst)
        !por_rst |-> refclk_en);
    // R5: clock output only while the PHY is out of reset
    p_oen_needs_rel_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_word[BIT_OEN] |-> !por_rst);
    // R3: rejection leaves the sequencer idle
    p_err_idle_r3: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !done));
    // R2: register write enable is a single pulse inside a sequence
    p_we_single_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> !ctrl_we);
    // R6: test-port fields move only in the test-port phase
    p_tp_after_settle_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(tp) |-> ($past(state) == ST_TPORT));
    // R10: a running sequence cannot be dropped before its finish step
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && state != ST_FIN) |=> busy);

    generate
        if (FIXED_USB3) begin : g_fixed
            // R4: fixed-mode instance never writes the mode field
            p_fixed_no_we_r4: assert property (@(posedge clk) disable iff (rst)
                !ctrl_we);
        end
    endgenerate

endmodule

// File: tb/tb_combo_phy_seq.sv
module tb_combo_phy_seq;
    localparam int S1 = 20;
    localparam int S0 = 7;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic init_req, exit_req;
    logic [1:0] mode_req;
    logic [31:0] ctrl_in, ctrl_out, cfg_word;
    logic ctrl_we, refclk_en, por_rst, busy, done, err;

    logic init0, exit0;
    logic [1:0] mode0;
    logic [31:0] cout0, cfg0;
    logic we0, refclk0, por0, busy0, done0, err0;

    combo_phy_seq #(.INSTANCE(1), .SETTLE_CYCLES(S1)) dut (
        .clk(clk), .rst(rst), .init_req(init_req), .exit_req(exit_req),
        .mode_req(mode_req), .ctrl_in(ctrl_in), .ctrl_out(ctrl_out), .ctrl_we(ctrl_we),
        .cfg_word(cfg_word), .refclk_en(refclk_en), .por_rst(por_rst), .busy(busy),
        .done(done), .err(err));

    combo_phy_seq #(.INSTANCE(0), .SETTLE_CYCLES(S0)) dut0 (
        .clk(clk), .rst(rst), .init_req(init0), .exit_req(exit0),
        .mode_req(mode0), .ctrl_in(32'hFFFF_FFFF), .ctrl_out(cout0), .ctrl_we(we0),
        .cfg_word(cfg0), .refclk_en(refclk0), .por_rst(por0), .busy(busy0),
        .done(done0), .err(err0));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [3:0] model [32];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rmw(input logic [31:0] c, input logic [1:0] m);
        return (c & ~32'h0000_1800) | ({30'b0, m} << 11);
    endfunction

    function automatic logic [4:0] exp_addr(input int i);
        return (i == 0) ? 5'h01 : (i == 1) ? 5'h0C : 5'h1A;
    endfunction

    function automatic logic [3:0] exp_data(input int i);
        return (i == 0) ? 4'h8 : (i == 1) ? 4'h9 : 4'h4;
    endfunction

    task automatic run_init(input logic [1:0] m, input logic [31:0] cin,
                            input bit poke, input bit fresh);
        logic [31:0] pc;
        int t_byp = -1, t_clk = -1, t_rel = -1, t_oen = -1, t_tp = -1;
        int we_n = 0, wr_n = 0, done_n = 0, k;
        bit busy_ok = 1, stab_ok = 1, order_ok = 1;
        logic [31:0] we_v = '0;
        logic pclk, ppor;
        pc = cfg_word; pclk = refclk_en; ppor = por_rst;
        ctrl_in = cin; mode_req = m; init_req = 1'b1;
        @(posedge clk); @(negedge clk);
        init_req = 1'b0;
        for (k = 0; k < 400; k++) begin
            if (ctrl_we) begin we_n++; we_v = ctrl_out; end
            if (pc[31] && !cfg_word[31]) t_byp = k;
            if (!pclk && refclk_en) t_clk = k;
            if (ppor && !por_rst) t_rel = k;
            if (!pc[0] && cfg_word[0]) t_oen = k;
            if (t_tp < 0 && cfg_word[24:12] != pc[24:12]) t_tp = k;
            if (pc[24] != cfg_word[24] && cfg_word[23:12] != pc[23:12]) stab_ok = 0;
            if (!pc[24] && cfg_word[24]) begin
                model[cfg_word[16:12]] = cfg_word[23:20];
                if (wr_n < 3 && (cfg_word[16:12] != exp_addr(wr_n) ||
                                 cfg_word[23:20] != exp_data(wr_n))) order_ok = 0;
                wr_n++;
            end
            if (done) begin done_n++; if (busy) busy_ok = 0; break; end
            if (!busy) busy_ok = 0;
            pc = cfg_word; pclk = refclk_en; ppor = por_rst;
            @(negedge clk);
            if (poke && k == 3) begin
                init_req = 1'b1; exit_req = 1'b1; mode_req = 2'd2;
            end else begin
                init_req = 1'b0; exit_req = 1'b0; mode_req = m;
            end
        end
        chk(done_n == 1 && busy_ok, "R10 busy until single done", done_n, 1);
        chk(we_n == 1 && we_v == exp_rmw(cin, m), "R2 read-modify-write", we_v, exp_rmw(cin, m));
        chk(wr_n == 3 && order_ok, "R8 test-port write list", wr_n, 3);
        chk(stab_ok, "R7 addr/data stable at strobe edges", stab_ok, 1);
        chk(model[5'h01] == 4'h8 && model[5'h0C] == 4'h9 && model[5'h1A] == 4'h4,
            "R7 latched values", {model[5'h01], model[5'h0C], model[5'h1A]}, 32'h894);
        if (t_oen >= 0)
            chk(t_tp - t_oen >= S1, "R6 settle distance", t_tp - t_oen, S1);
        if (fresh)
            chk(t_byp >= 0 && t_byp < t_clk && t_clk < t_rel && t_rel < t_oen,
                "R5 power-up order", {t_byp[7:0], t_clk[7:0], t_rel[7:0], t_oen[7:0]}, 0);
        chk(refclk_en && !por_rst && cfg_word[0] && !cfg_word[31], "R5 powered end state",
            cfg_word, 32'h0);
    endtask

    task automatic run_exit(input bit poke);
        logic [31:0] pc;
        logic pclk, ppor;
        int t_oen = -1, t_rst = -1, t_clk = -1, we_n = 0, rise_n = 0, done_n = 0, k;
        bit up;
        up = refclk_en;
        pc = cfg_word; pclk = refclk_en; ppor = por_rst;
        exit_req = 1'b1;
        @(posedge clk); @(negedge clk);
        exit_req = 1'b0;
        for (k = 0; k < 50; k++) begin
            if (ctrl_we) we_n++;
            if (pc[0] && !cfg_word[0]) t_oen = k;
            if (!ppor && por_rst) t_rst = k;
            if (pclk && !refclk_en) t_clk = k;
            if (!pc[24] && cfg_word[24]) rise_n++;
            if (done) begin done_n++; break; end
            pc = cfg_word; pclk = refclk_en; ppor = por_rst;
            @(negedge clk);
            if (poke && k == 1) begin init_req = 1'b1; mode_req = 2'd1; end
            else init_req = 1'b0;
        end
        init_req = 1'b0;
        chk(done_n == 1, "R10 exit done", done_n, 1);
        if (up)
            chk(t_oen >= 0 && t_oen < t_rst && t_rst < t_clk, "R9 power-down order",
                {t_oen[7:0], t_rst[7:0], t_clk[7:0]}, 0);
        chk(we_n == 0 && rise_n == 0, "R9 no writes on exit", {we_n[15:0], rise_n[15:0]}, 0);
        chk(!refclk_en && por_rst && !cfg_word[0], "R9 off end state", cfg_word, 0);
    endtask

    task automatic reject(input logic [1:0] m);
        logic [31:0] c;
        logic rc, rp;
        c = cfg_word; rc = refclk_en; rp = por_rst;
        mode_req = m; init_req = 1'b1;
        @(posedge clk); @(negedge clk);
        init_req = 1'b0;
        chk(err && !busy && !ctrl_we, "R3 reject pulse", {err, busy, ctrl_we}, 3'b100);
        chk(cfg_word == c && refclk_en == rc && por_rst == rp, "R3 state unchanged", cfg_word, c);
        @(negedge clk);
        chk(!err && !busy, "R3 err one cycle", {err, busy}, 0);
    endtask

    task automatic run0(input logic [1:0] m);
        int we_n = 0, k;
        bit dn = 0;
        mode0 = m; init0 = 1'b1;
        @(posedge clk); @(negedge clk);
        init0 = 1'b0;
        if (m != 2'd1) begin
            chk(err0 && !busy0, "R4 fixed instance rejects", {err0, busy0}, 2'b10);
        end else begin
            for (k = 0; k < 200; k++) begin
                if (we0) we_n++;
                if (done0) begin dn = 1; break; end
                @(negedge clk);
            end
            chk(dn && we_n == 0 && refclk0 && !por0, "R4 fixed instance init, no mode write",
                we_n, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit up;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst = 1'b1; init_req = 0; exit_req = 0; mode_req = 0; ctrl_in = 0;
        init0 = 0; exit0 = 0; mode0 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(cfg_word == 32'h8000_0000 && !refclk_en && por_rst && !busy && !done && !err
            && !ctrl_we, "R1 reset state", cfg_word, 32'h8000_0000);
        chk(cfg0 == 32'h8000_0000 && por0 && !refclk0, "R1 reset state fixed instance",
            cfg0, 32'h8000_0000);

        reject(2'd3);
        run_init(2'd2, 32'hA5A5_5A5A, 1'b0, 1'b1);
        run_exit(1'b0);
        run_init(2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
        run_exit(1'b1);
        run_init(2'd1, 32'h0000_0000, 1'b0, 1'b0);

        run0(2'd0); run0(2'd2); run0(2'd3); run0(2'd1);

        up = 1;
        for (int it = 0; it < 30; it++) begin
            int op;
            op = $urandom % 4;
            if (op == 0) begin run_exit(1'b0); up = 0; end
            else if (op == 1) reject(2'd3);
            else begin
                run_init(2'($urandom % 3), $urandom, (op == 3), 1'b0);
                up = 1;
            end
            @(negedge clk);
        end
        chk(refclk_en == up, "R9 tracked power state", refclk_en, up);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule